// File: doc/BRIEF.md
# Strided Dot-Product Engine

This block computes the dot product of two operand arrays held in a local scratchpad. Software first writes the configuration registers: a start address and an address step for each of the two arrays, plus an element count. It then reads the result register. That read launches the computation, and the response is held back until the sum is ready. The unit walks both arrays through a single scratchpad read port, fetching the first operand of a pair and then the second. It multiplies the two 16-bit signed values and adds the product into a 40-bit accumulator. The returned value is that accumulator clamped to the signed 32-bit range.

The configuration stays in place after an operation finishes, so a kernel that reuses the same shape only needs to rewrite the fields that change. The sequencer has four states:

- `ST_IDLE` waits for a read.
- `ST_FETCH` issues one scratchpad request per cycle, alternating between the first and second operand.
- `ST_DRAIN` waits three cycles for the last pair to pass through the port latency and the two-stage multiply-add.
- `ST_DONE` presents the response for one cycle.

The transitions are:

- `ST_IDLE` goes to `ST_FETCH` on a result read with a nonzero count.
- `ST_IDLE` goes straight to `ST_DONE` on any other read.
- `ST_FETCH` goes to `ST_DRAIN` after the second-operand request of the last pair.
- `ST_DRAIN` goes to `ST_DONE` after its third cycle.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `strided_dot_engine`

## Requirements
- R1: Writes at word offsets 0xC0 (first array start), 0xC8 (first array step), 0xD0 (second array start), 0xD8 (second array step) and 0xF0 (element count) load those fields from the low bits of `wr_data`. A write at any other offset has no effect on later results.
- R2: A read at offset 0xF8 accepted in `ST_IDLE` produces exactly one cycle with `rd_valid` high, carrying the result on `rd_data`. `rd_data` is zero whenever `rd_valid` is low.
- R3: For pair k, with k running from 0 to N-1, the first operand is read from start_a + k*step_a and the second from start_b + k*step_b, both modulo 2^AW. The two requests of a pair are issued on consecutive cycles in the order first, second. Exactly 2N requests are issued, with no idle cycles between them.
- R4: The result is the sum over all pairs of the signed 16-bit product. The accumulator is cleared at every accepted read, so no earlier sum leaks into the result.
- R5: Count the clock edge that samples the triggering read as edge 0. For N > 0, `rd_valid` is high in the cycle that follows edge 2N+3. For N = 0, it is high in the cycle right after edge 0, with data 0 and no scratchpad request.
- R6: A sum above 2^31-1 returns 0x7FFFFFFF. A sum below -2^31 returns 0x80000000.
- R7: Configuration fields keep their values across operations until they are rewritten. A second trigger with no writes in between returns the same result.
- R8: A write accepted while an operation is running, or in the same cycle as its trigger, does not change that operation. It takes effect from the next trigger.
- R9: A read issued while an operation is running is ignored. It does not produce an extra response and does not restart the operation. A read at an offset other than 0xF8 returns 0 one cycle later without touching the scratchpad.
- R10: After reset, `sp_req` and `rd_valid` are low and all configuration fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write word offset |
| wr_data | input | AW (10) | Register write data |
| rd_req | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read word offset |
| rd_valid | output | 1 | Read response valid, one cycle |
| rd_data | output | OW (32) | Read response data |
| sp_req | output | 1 | Scratchpad read request |
| sp_addr | output | AW (10) | Scratchpad read address |
| sp_rvalid | input | 1 | Scratchpad data valid, two cycles after the request |
| sp_rdata | input | DW (16) | Scratchpad read data, signed |

## Verification
The assertions check several properties on every cycle:

- A response lasts a single cycle.
- No response is presented while scratchpad requests are still being issued.
- The number of returned scratchpad beats matches twice the latched count when the response is presented.
- Every second operand produces a product in the cycle that follows.
- The configuration is unchanged on cycles without a write.

Only the bench's scenarios can show the rest:

- The arithmetic value of the sum and its clamping.
- The exact address sequence, including wrap-around and zero steps.
- The cycle on which the response appears.
- The deferral of writes made during an operation.
- The ignoring of reads issued during an operation.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_DONE
    } sdp_state_e;

    localparam logic [7:0] OFF_START_A = 8'hC0;
    localparam logic [7:0] OFF_STEP_A  = 8'hC8;
    localparam logic [7:0] OFF_START_B = 8'hD0;
    localparam logic [7:0] OFF_STEP_B  = 8'hD8;
    localparam logic [7:0] OFF_COUNT   = 8'hF0;
    localparam logic [7:0] OFF_RESULT  = 8'hF8;

    // cycles spent in ST_DRAIN: two of port latency plus one of accumulate
    localparam int unsigned DRAIN_CYCLES = 3;

endpackage

// File: rtl/sdp_cfg_regs.sv
module sdp_cfg_regs
    import sdp_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] start_a,
    output logic [AW-1:0] step_a,
    output logic [AW-1:0] start_b,
    output logic [AW-1:0] step_b,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_a <= '0;
            step_a  <= '0;
            start_b <= '0;
            step_b  <= '0;
            count   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                OFF_START_A: start_a <= wr_data;
                OFF_STEP_A:  step_a  <= wr_data;
                OFF_START_B: start_b <= wr_data;
                OFF_STEP_B:  step_b  <= wr_data;
                OFF_COUNT:   count   <= wr_data[CW-1:0];
                default: ;
            endcase
        end
    end

    // R7: the configuration holds on every cycle without a write
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(start_a) && $stable(step_a) && $stable(start_b)
                    && $stable(step_b) && $stable(count)));

endmodule

// File: rtl/sdp_walker.sv
module sdp_walker #(
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    output logic [AW-1:0] ptr
);

    // the stride is captured at load, so later register writes cannot bend the walk
    logic [AW-1:0] stride_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr      <= '0;
            stride_q <= '0;
        end else if (load) begin
            ptr      <= base;
            stride_q <= stride;
        end else if (step) begin
            ptr      <= ptr + stride_q;
        end
    end

endmodule

// File: rtl/sdp_mac.sv
module sdp_mac #(
    parameter int unsigned DW   = 16,
    parameter int unsigned ACCW = 40,
    parameter int unsigned OW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic        [OW-1:0] result
);

    localparam int unsigned PW = 2 * DW;
    localparam logic signed [ACCW-1:0] SAT_HI = {{(ACCW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] SAT_LO = {{(ACCW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic                   rx_second;
    logic signed [DW-1:0]   a_hold;
    logic signed [PW-1:0]   prod;
    logic                   prod_v;
    logic signed [ACCW-1:0] acc;

    // stage 1: pair up operands and multiply; stage 2: accumulate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_second <= 1'b0;
            a_hold    <= '0;
            prod      <= '0;
            prod_v    <= 1'b0;
            acc       <= '0;
        end else if (clr) begin
            rx_second <= 1'b0;
            prod_v    <= 1'b0;
            acc       <= '0;
        end else begin
            prod_v <= in_valid && rx_second;
            if (in_valid) begin
                rx_second <= !rx_second;
                if (!rx_second) begin
                    a_hold <= in_data;
                end else begin
                    prod <= a_hold * in_data;
                end
            end
            if (prod_v) begin
                acc <= acc + {{(ACCW-PW){prod[PW-1]}}, prod};
            end
        end
    end

    always_comb begin
        if (acc > SAT_HI) begin
            result = SAT_HI[OW-1:0];
        end else if (acc < SAT_LO) begin
            result = SAT_LO[OW-1:0];
        end else begin
            result = acc[OW-1:0];
        end
    end

    // R4: every second operand of a pair yields a product on the next cycle
    assert_pair_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rx_second && !clr) |=> prod_v);

endmodule

// File: rtl/strided_dot_engine.sv
module strided_dot_engine
    import sdp_pkg::*;
#(
    parameter int unsigned AW   = 10,
    parameter int unsigned DW   = 16,
    parameter int unsigned CW   = 8,
    parameter int unsigned ACCW = 40,
    parameter int unsigned OW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [AW-1:0]        wr_data,
    input  logic                 rd_req,
    input  logic [7:0]           rd_addr,
    output logic                 rd_valid,
    output logic [OW-1:0]        rd_data,
    output logic                 sp_req,
    output logic [AW-1:0]        sp_addr,
    input  logic                 sp_rvalid,
    input  logic signed [DW-1:0] sp_rdata
);

    localparam int unsigned DCW = $clog2(DRAIN_CYCLES);
    localparam logic [DCW-1:0] DRAIN_LAST = DCW'(DRAIN_CYCLES - 1);

    sdp_state_e    state, state_nx;
    logic [AW-1:0] cfg_start [2];
    logic [AW-1:0] cfg_step  [2];
    logic [AW-1:0] ptr       [2];
    logic [1:0]    walk_step;
    logic [CW-1:0] cfg_count;
    logic [CW-1:0] pairs_left;
    logic          req_second;
    logic [DCW-1:0] drain_cnt;
    logic          accept_rd;
    logic          launch;
    logic [OW-1:0] mac_result;

    assign accept_rd = rd_req && (state == ST_IDLE);
    assign launch    = accept_rd && (rd_addr == OFF_RESULT) && (cfg_count != '0);

    sdp_cfg_regs #(.AW(AW), .CW(CW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .start_a (cfg_start[0]),
        .step_a  (cfg_step[0]),
        .start_b (cfg_start[1]),
        .step_b  (cfg_step[1]),
        .count   (cfg_count)
    );

    for (genvar g = 0; g < 2; g++) begin : g_walk
        sdp_walker #(.AW(AW)) u_walker (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (launch),
            .step   (walk_step[g]),
            .base   (cfg_start[g]),
            .stride (cfg_step[g]),
            .ptr    (ptr[g])
        );
    end

    sdp_mac #(.DW(DW), .ACCW(ACCW), .OW(OW)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept_rd),
        .in_valid (sp_rvalid),
        .in_data  (sp_rdata),
        .result   (mac_result)
    );

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pairs_left <= '0;
            req_second <= 1'b0;
            drain_cnt  <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    pairs_left <= cfg_count;
                    req_second <= 1'b0;
                    drain_cnt  <= '0;
                end
                ST_FETCH: begin
                    req_second <= !req_second;
                    if (req_second) begin
                        pairs_left <= pairs_left - 1'b1;
                    end
                end
                ST_DRAIN: drain_cnt <= drain_cnt + 1'b1;
                ST_DONE: ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) begin
                    state_nx = ST_FETCH;
                end else if (accept_rd) begin
                    state_nx = ST_DONE;
                end
            end
            ST_FETCH: begin
                if (req_second && pairs_left == CW'(1)) begin
                    state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (drain_cnt == DRAIN_LAST) begin
                    state_nx = ST_DONE;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sp_req    = (state == ST_FETCH);
        sp_addr   = req_second ? ptr[1] : ptr[0];
        walk_step = {sp_req && req_second, sp_req && !req_second};
        rd_valid  = (state == ST_DONE);
        rd_data   = rd_valid ? mac_result : '0;
    end

    // checker-side beat counter for the returned-data assertion
    logic [CW:0]   beats_seen;
    logic [CW-1:0] op_pairs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_seen <= '0;
            op_pairs   <= '0;
        end else if (accept_rd) begin
            beats_seen <= '0;
            op_pairs   <= launch ? cfg_count : '0;
        end else if (sp_rvalid) begin
            beats_seen <= beats_seen + 1'b1;
        end
    end

    // R2: a response lasts exactly one cycle
    assert_single_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R5: no response while requests are still being issued
    assert_no_early_response_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sp_req |-> !rd_valid);

    // R3: all 2N data beats have come back when the response is presented
    assert_beats_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (beats_seen == {op_pairs, 1'b0}));

endmodule

// File: tb/strided_dot_engine_tb_top.sv
module strided_dot_engine_tb_top;

    localparam int AW = 10;
    localparam int DW = 16;
    localparam int OW = 32;
    localparam int MEMN = 1 << AW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [7:0]           wr_addr = '0;
    logic [AW-1:0]        wr_data = '0;
    logic                 rd_req = 1'b0;
    logic [7:0]           rd_addr = '0;
    logic                 rd_valid;
    logic [OW-1:0]        rd_data;
    logic                 sp_req;
    logic [AW-1:0]        sp_addr;
    logic                 sp_rvalid;
    logic signed [DW-1:0] sp_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = !clk;

    strided_dot_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sp_req(sp_req), .sp_addr(sp_addr),
        .sp_rvalid(sp_rvalid), .sp_rdata(sp_rdata)
    );

    // scratchpad model with a fixed two-cycle read latency
    logic signed [DW-1:0] mem [MEMN];
    logic s1_v = 1'b0, s2_v = 1'b0;
    logic signed [DW-1:0] s1_d = '0, s2_d = '0;
    always @(posedge clk) begin
        s1_v <= sp_req;
        s1_d <= mem[sp_addr];
        s2_v <= s1_v;
        s2_d <= s1_d;
    end
    assign sp_rvalid = s2_v;
    assign sp_rdata  = s2_d;

    // shadow of the configuration as the bench believes it to be
    int sh_sa = 0, sh_ta = 0, sh_sb = 0, sh_tb = 0, sh_n = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void shadow_write(input logic [7:0] off, input int val);
        case (off)
            8'hC0: sh_sa = val % MEMN;
            8'hC8: sh_ta = val % MEMN;
            8'hD0: sh_sb = val % MEMN;
            8'hD8: sh_tb = val % MEMN;
            8'hF0: sh_n  = val % 256;
            default: ;
        endcase
    endfunction

    task automatic reg_write(input logic [7:0] off, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = off; wr_data = AW'(val);
        @(negedge clk);
        wr_en = 1'b0;
        shadow_write(off, val);
    endtask

    function automatic longint expected_sum(input int sa, input int ta, input int sb, input int tb, input int n);
        longint s = 0;
        for (int k = 0; k < n; k++) begin
            s += longint'(mem[(sa + k * ta) % MEMN]) * longint'(mem[(sb + k * tb) % MEMN]);
        end
        if (s > 64'sd2147483647) s = 64'sd2147483647;
        if (s < -64'sd2147483648) s = -64'sd2147483648;
        return s;
    endfunction

    // mid: 0 none, 1 write a new count during the run, 2 extra result read during the run,
    // 3 count write in the same cycle as the trigger
    int new_count = 0;
    task automatic run_op(input string tag, input logic [7:0] off, input int mid);
        int sa = sh_sa, ta = sh_ta, sb = sh_sb, tb = sh_tb, n = sh_n;
        int eff_n, lat_exp, lat_act, nvalid, nreq, bad_addr;
        longint exp_res, got_res;
        eff_n = (off == 8'hF8) ? n : 0;
        lat_exp = (eff_n == 0) ? 0 : 2 * eff_n + 3;
        exp_res = (eff_n == 0) ? 0 : expected_sum(sa, ta, sb, tb, eff_n);
        lat_act = -1; nvalid = 0; nreq = 0; bad_addr = 0; got_res = 0;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = off;
        if (mid == 3) begin
            wr_en = 1'b1; wr_addr = 8'hF0; wr_data = AW'(new_count);
        end
        for (int w = 0; w < 2 * eff_n + 10; w++) begin
            @(negedge clk);
            rd_req = 1'b0; wr_en = 1'b0;
            if (w == 0 && mid == 3) shadow_write(8'hF0, new_count);
            if (w == 1 && mid == 1) begin
                wr_en = 1'b1; wr_addr = 8'hF0; wr_data = AW'(new_count);
            end
            if (w == 2 && mid == 1) shadow_write(8'hF0, new_count);
            if (w == 1 && mid == 2) begin
                rd_req = 1'b1; rd_addr = 8'hF8;
            end
            if (sp_req) begin
                int k = nreq / 2;
                int ea = (nreq % 2 == 0) ? (sa + k * ta) % MEMN : (sb + k * tb) % MEMN;
                if (int'(sp_addr) != ea) bad_addr++;
                nreq++;
            end
            if (rd_valid) begin
                nvalid++;
                if (lat_act < 0) begin
                    lat_act = w;
                    got_res = longint'(signed'(rd_data));
                end
            end else if (rd_data != '0) begin
                bad_addr += 1000;
            end
        end
        check("R5", {tag, " response cycle"}, lat_act, lat_exp);
        check("R2", {tag, " response count"}, nvalid, 1);
        check("R4", {tag, " result"}, got_res, exp_res);
        check("R3", {tag, " request count"}, nreq, 2 * eff_n);
        check("R3", {tag, " address errors / R2 idle data"}, bad_addr, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMN; i++) mem[i] = DW'($urandom);
        repeat (3) @(negedge clk);
        check("R10", "sp_req in reset", sp_req, 0);
        check("R10", "rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "sp_req after reset", sp_req, 0);

        // R10, R5: zero configuration gives an immediate zero response
        run_op("R10 zero cfg", 8'hF8, 0);

        // R1, R3: basic single pair and a short walk
        reg_write(8'hC0, 10); reg_write(8'hC8, 1);
        reg_write(8'hD0, 200); reg_write(8'hD8, 2);
        reg_write(8'hF0, 1);
        run_op("R1 single pair", 8'hF8, 0);
        reg_write(8'hF0, 6);
        run_op("R3 six pairs", 8'hF8, 0);

        // R7: repeat with no writes returns the same result
        run_op("R7 repeat", 8'hF8, 0);

        // R1: unmapped write offset changes nothing
        reg_write(8'hE0, 77);
        run_op("R1 unmapped write", 8'hF8, 0);

        // R9: read at a different offset returns zero without fetching
        run_op("R9 other offset", 8'hC0, 0);

        // R9: result read while busy is ignored
        run_op("R9 busy read", 8'hF8, 2);

        // R8: count written during a run applies only to the next trigger
        new_count = 3;
        run_op("R8 busy write", 8'hF8, 1);
        run_op("R8 next trigger", 8'hF8, 0);
        new_count = 5;
        run_op("R8 same-cycle write", 8'hF8, 3);
        run_op("R8 after same-cycle", 8'hF8, 0);

        // R3: wrap-around and zero steps
        reg_write(8'hC0, 1020); reg_write(8'hC8, 3);
        reg_write(8'hD0, 7); reg_write(8'hD8, 0);
        reg_write(8'hF0, 5);
        run_op("R3 wrap and zero step", 8'hF8, 0);

        // R6: saturation in both directions
        mem[5] = -16'sd32768; mem[6] = 16'sd32767;
        reg_write(8'hC0, 5); reg_write(8'hC8, 0);
        reg_write(8'hD0, 5); reg_write(8'hD8, 0);
        reg_write(8'hF0, 4);
        run_op("R6 saturate high", 8'hF8, 0);
        reg_write(8'hD0, 6);
        run_op("R6 saturate low", 8'hF8, 0);

        // R4: constrained random operations
        for (int t = 0; t < 20; t++) begin
            reg_write(8'hC0, int'($urandom % MEMN));
            reg_write(8'hC8, int'($urandom % MEMN));
            reg_write(8'hD0, int'($urandom % MEMN));
            reg_write(8'hD8, int'($urandom % MEMN));
            reg_write(8'hF0, int'(1 + $urandom % 16));
            run_op("R4 random", 8'hF8, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule